// File: doc/BRIEF.md
# Comb-Filter Stereo Synthesizer

This block turns a single stream of signed mono audio samples into a left and right pair. Each accepted sample is stored in a circular delay buffer, and one delayed copy is read back from a fixed distance behind the write position. The right output is the sample plus that delayed copy. The left output is the sample minus the delayed copy. The two channels therefore have comb responses whose peaks and notches interleave, which spreads a mono source across the stereo field.

The delay length is chosen by a 3-bit selection code from eight settings, each a whole multiple of a step length. The step length is a parameter; at a 500 kHz sample rate a step of 250 samples gives 0.5 ms. The code is captured only while reset is held, so a running stream never sees its delay change. Both sums saturate at the signed sample range. Each result pair is flagged valid one clock after its input sample is accepted.

Top module: `comb_stereo`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `out_valid` is 0 and both `out_left` and `out_right` are 0.
- R2: `out_valid` is high in exactly the clock after a clock in which `in_valid` was high; when `in_valid` is low, `out_left` and `out_right` keep their previous values.
- R3: For each accepted sample x with delayed copy d, `out_right` equals x + d, saturated as in R7.
- R4: For each accepted sample x with delayed copy d, `out_left` equals x - d, saturated as in R7.
- R5: The delayed copy d is the sample accepted exactly L accepted samples earlier, where L = (code + 1) × STEP_LEN and code is the unsigned value of `sel_code` (bit 2 most significant). Code 0 gives the shortest delay and code 7 the longest; a switch bank that reads "on" as 0 maps directly onto this code.
- R6: Until L samples have been accepted since reset, the delayed copy reads as 0, so both outputs equal the input sample.
- R7: An output whose true sum lies above 2^(SAMPLE_W-1) - 1 becomes 2^(SAMPLE_W-1) - 1, and one below -2^(SAMPLE_W-1) becomes -2^(SAMPLE_W-1); no output wraps.
- R8: `sel_code` is sampled on clocks while `rst_n` is low; changes to it while `rst_n` is high have no effect on the delay.
- R9: Clocks with `in_valid` low do not advance the delay: L counts accepted samples, not clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; delay code is captured while low |
| sel_code | input | 3 | Delay selection code, length = (code + 1) × STEP_LEN samples |
| in_valid | input | 1 | High when `in_sample` carries a new sample |
| in_sample | input | SAMPLE_W | Signed mono input sample |
| out_valid | output | 1 | High one clock after an accepted sample |
| out_left | output | SAMPLE_W | Signed difference output, saturated |
| out_right | output | SAMPLE_W | Signed sum output, saturated |

## Verification
The bench builds the block with SAMPLE_W = 8 and STEP_LEN = 3, so the buffer holds 24 samples and every one of the eight delay lengths (3 to 24 samples) fills and wraps within a few dozen samples per run. The narrow sample width puts both saturation limits within easy reach of ordinary stimulus, and a behavioural queue model compares both outputs and the valid flag on every clock across runs with gaps in the input stream and with the selection code moved after reset.

// File: rtl/comb_pkg.sv
package comb_pkg;

  localparam int CODE_W = 3;

  // Clamp a signed integer into the range of a w-bit two's complement value.
  function automatic int sat_clip(int value, int w);
    int hi;
    int lo;
    hi = (1 <<< (w - 1)) - 1;
    lo = -(1 <<< (w - 1));
    if (value > hi) return hi;
    if (value < lo) return lo;
    return value;
  endfunction

  // Delay length in samples for a given selection code.
  function automatic int delay_len(int code, int step);
    return (code + 1) * step;
  endfunction

endpackage

// File: rtl/comb_delay_sel.sv
module comb_delay_sel #(
  parameter int STEP_LEN = 250,
  parameter int CODE_W   = 3,
  parameter int LEN_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_code,
  output logic [LEN_W-1:0]  len
);
  import comb_pkg::*;

  logic [CODE_W-1:0] code_q;

  // Code is loaded on every clock while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= sel_code;
  end

  assign len = LEN_W'(delay_len(int'(code_q), STEP_LEN));

  // R8
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(code_q));

endmodule

// File: rtl/comb_ring_buf.sv
module comb_ring_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 2000,
  parameter int LEN_W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic signed [W-1:0] din,
  input  logic [LEN_W-1:0]    len,
  output logic signed [W-1:0] tap,
  output logic                filled
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             at_end;

  assign at_end = (LEN_W'(ptr) == len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      filled <= 1'b0;
    end else if (wr_en) begin
      ptr <= at_end ? '0 : ptr + PTR_W'(1);
      if (at_end) filled <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= din;
  end

  // The slot about to be overwritten holds the sample from len writes ago.
  assign tap = filled ? signed'(mem[ptr]) : '0;

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LEN_W'(ptr) < len);

  // R6
  fill_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filled) |-> ptr == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr));

endmodule

// File: rtl/comb_mix.sv
module comb_mix #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] tap,
  output logic                out_valid,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right
);
  import comb_pkg::*;

  logic signed [W-1:0] sum_n;
  logic signed [W-1:0] diff_n;

  assign sum_n  = W'(sat_clip(int'(x) + int'(tap), W));
  assign diff_n = W'(sat_clip(int'(x) - int'(tap), W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= diff_n;
        out_right <= sum_n;
      end
    end
  end

  // R2
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_left) && $stable(out_right)));

  // R7
  sum_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x >= 0 && tap >= 0) |=> out_right >= 0);

  // R7
  sum_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x < 0 && tap < 0) |=> out_right < 0);

  // R4
  diff_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && x >= 0 && tap < 0) |=> out_left >= 0);

endmodule

// File: rtl/comb_stereo.sv
module comb_stereo #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_LEN = 250,
  parameter int CODE_W   = comb_pkg::CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CODE_W-1:0]          sel_code,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);
  localparam int DEPTH = STEP_LEN * (1 << CODE_W);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [LEN_W-1:0]           len;
  logic signed [SAMPLE_W-1:0] tap;
  logic                       filled;

  comb_delay_sel #(
    .STEP_LEN (STEP_LEN),
    .CODE_W   (CODE_W),
    .LEN_W    (LEN_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_code (sel_code),
    .len      (len)
  );

  comb_ring_buf #(
    .W     (SAMPLE_W),
    .DEPTH (DEPTH),
    .LEN_W (LEN_W)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (in_valid),
    .din    (in_sample),
    .len    (len),
    .tap    (tap),
    .filled (filled)
  );

  comb_mix #(
    .W (SAMPLE_W)
  ) u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x         (in_sample),
    .tap       (tap),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // R6
  empty_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |-> tap == '0);

endmodule

// File: tb/comb_stereo_bench.sv
`timescale 1ns/1ps
module comb_stereo_bench;
  localparam int W    = 8;
  localparam int STEP = 3;
  localparam int HI   = 127;
  localparam int LO   = -128;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2:0]          sel_code = 3'd0;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic                out_valid;
  logic signed [W-1:0] out_left;
  logic signed [W-1:0] out_right;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int    hist[$];
  int    cur_len;
  bit    exp_v;
  int    exp_l;
  int    exp_r;
  string tag_l;
  string tag_r;
  string ctx;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  comb_stereo #(.SAMPLE_W(W), .STEP_LEN(STEP)) u_comb_stereo (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
  );

  function automatic int clip(int v);
    return (v > HI) ? HI : ((v < LO) ? LO : v);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]) - 128;
  endfunction

  task automatic do_reset(int code);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    sel_code = code[2:0];
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(out_left == '0, "R1 left in reset", int'(out_left), 0);
    chk(out_right == '0, "R1 right in reset", int'(out_right), 0);
    rst_n = 1'b1;
    hist.delete();
    cur_len = (code + 1) * STEP;
    exp_v = 0; exp_l = 0; exp_r = 0;
    tag_l = "R1"; tag_r = "R1";
  endtask

  // One clock: compare outputs with the previous cycle's expectation, then drive.
  task automatic step(bit v, int x);
    int idx;
    int d;
    chk(out_valid == exp_v, {"R2 valid ", ctx}, int'(out_valid), int'(exp_v));
    chk(int'(out_left) == exp_l, {"R4 left ", tag_l}, int'(out_left), exp_l);
    chk(int'(out_right) == exp_r, {"R3 right ", tag_r}, int'(out_right), exp_r);
    in_valid = v;
    in_sample = x[W-1:0];
    if (v) begin
      idx = hist.size();
      d = (idx >= cur_len) ? hist[idx - cur_len] : 0;
      hist.push_back(x);
      exp_l = clip(x - d);
      exp_r = clip(x + d);
      tag_l = (idx < cur_len) ? "R6" : ((exp_l != x - d) ? "R7" : ctx);
      tag_r = (idx < cur_len) ? "R6" : ((exp_r != x + d) ? "R7" : ctx);
    end else begin
      tag_l = {"R2 hold ", ctx};
      tag_r = {"R2 hold ", ctx};
    end
    exp_v = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Shortest delay, random data: R5 and fill phase R6.
    ctx = "R5 code0";
    do_reset(0);
    for (int i = 0; i < 40; i++) step(1, next_rand());
    step(0, 0);

    // Longest delay with large same-signed values: saturation R7.
    ctx = "R5 code7";
    do_reset(7);
    for (int i = 0; i < 70; i++) step(1, (next_rand() >= 0) ? 110 : -115);
    step(1, HI); step(1, LO); step(1, HI);
    step(0, 0);

    // Gaps in the stream: delay counts accepted samples, R9.
    ctx = "R9 gaps";
    do_reset(3);
    for (int i = 0; i < 90; i++) begin
      if ((i % 3) == 1) step(0, 55);
      else step(1, next_rand());
    end
    step(0, 0);

    // Code moved after reset must be ignored, R8.
    ctx = "R8 frozen";
    do_reset(5);
    for (int i = 0; i < 60; i++) begin
      if (i == 5) sel_code = 3'd0;
      if (i == 30) sel_code = 3'd7;
      step(1, next_rand());
    end
    step(0, 0);

    // Remaining codes with a ramp and an impulse.
    for (int c = 1; c < 7; c++) begin
      ctx = "R5 sweep";
      do_reset(c);
      step(1, 90);
      for (int i = 0; i < 30; i++) step(1, 0);
      for (int i = 0; i < 20; i++) step(1, i * 6 - 60);
      step(0, 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule